// File: doc/BRIEF.md
# Configuration-space I/O window decoder

This block holds the configuration bytes that place and switch on two I/O windows of a function on a PCI bus: a 64-byte power-management window and a smaller SMBus controller window. Configuration writes arrive as a dword address, four byte enables and 32 bits of data. Each window owns two pieces of configuration storage: a 32-bit base dword and a separate enable byte. The window's effective base is the base dword masked to 64-byte alignment over a 16-bit I/O space, and its enable is bit 0 of the enable byte.

A write that touches any byte of a window's base dword or its enable byte makes that window re-derive its base and enable from the new register contents, at the same clock edge as the write. Incoming I/O addresses are then decoded combinationally against both windows. Each window reports a hit and the offset of the address from its base. Configuration readback is combinational. It returns the stored bytes, and returns zero for any dword the block does not own.

Top module: `io_win_decoder`

## Requirements
- R1: After reset, power-management base dword 0x40 reads 0x00000001, enable dword 0x80 reads 0x00000000, and `pm_hit_o` is 0 for every address.
- R2: After reset, SMBus base dword 0x90 reads `{16'h0, SMB_BASE | 1}`. Enable byte 0xD2 (lane 2 of dword 0xD0) reads 0x09. The SMBus window is open at `SMB_BASE`.
- R3: The power-management base is the dword at 0x40 ANDed with 0xFFC0. Bit 0 of byte 0x40 always reads 1, whatever value is written.
- R4: The power-management window is open exactly when bit 0 of byte 0x80 is 1. The other bits of that byte are stored and read back but do not affect decoding.
- R5: The SMBus base is the dword at 0x90 ANDed with 0xFFC0. That window is open exactly when bit 0 of byte 0xD2 is 1.
- R6: Byte enable bit i writes only byte lane i (data bits 8i+7..8i). A write to lane 1 of dword 0x40 alone moves the base. A write to lane 2 alone changes the readback but not the base.
- R7: A window hits when it is open and base <= address < base + size. The size is 64 for power management and `SMB_SIZE` for SMBus. The offset output is the address minus the base.
- R8: A configuration write changes readback, hit and offset from the clock edge that accepts it. The very next read or decode already sees the new values.
- R9: Writes to dwords or byte lanes that no window owns change no readback and no window. Dwords that no window owns read 0.
- R10: A window's base and enable change only on a cycle that carries a configuration write. With no write and a steady address, hit outputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_waddr_i | input | 6 | Dword address of the write (byte offset / 4) |
| cfg_be_i | input | 4 | Byte-lane enables of the write |
| cfg_wdata_i | input | 32 | Write data, little-endian lanes |
| cfg_raddr_i | input | 6 | Dword address of the readback |
| cfg_rdata_o | output | 32 | Readback data, combinational |
| io_addr_i | input | IO_AW (16) | I/O address to decode |
| pm_hit_o | output | 1 | Address falls in the power-management window |
| pm_off_o | output | 6 | Offset within the power-management window |
| smb_hit_o | output | 1 | Address falls in the SMBus window |
| smb_off_o | output | 6 | Offset within the SMBus window |

## Verification
The only register stage lies between a configuration write and its effect. Readback, hit and offset therefore all become valid in the same cycle that follows the edge accepting the write, with zero extra cycles of latency for decoding. Each directed task drives its write on a falling edge and holds it through one rising edge. It drops the strobe on the next falling edge and applies read address and I/O address there, then samples one time unit later, well clear of the next rising edge. In this way every check looks at the first cycle in which the requirement says the result is due (R8), never a later one.

// File: rtl/io_win_pkg.sv
package io_win_pkg;
  localparam int unsigned ALIGN_W = 6;          // 64-byte base alignment
  localparam int unsigned OFF_W   = ALIGN_W;
  localparam int unsigned NUM_WIN = 2;

  typedef enum int unsigned {
    WIN_PM  = 0,
    WIN_SMB = 1
  } win_id_e;

  function automatic logic lane_wr(input logic we, input logic [5:0] waddr,
                                   input logic [5:0] dw, input logic be_bit);
    return we && (waddr == dw) && be_bit;
  endfunction
endpackage

// File: rtl/io_win_cfg.sv
module io_win_cfg
  import io_win_pkg::*;
#(
  parameter int unsigned IO_AW     = 16,
  parameter logic [7:0]  BASE_OFF  = 8'h40,
  parameter logic [7:0]  EN_OFF    = 8'h80,
  parameter bit          RO_BIT0   = 1'b0,
  parameter logic [31:0] BASE_INIT = 32'h0,
  parameter logic [7:0]  EN_INIT   = 8'h0,
  localparam int unsigned BW = IO_AW - ALIGN_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [5:0]    waddr_i,
  input  logic [3:0]    be_i,
  input  logic [31:0]   wdata_i,
  input  logic [5:0]    raddr_i,
  output logic [31:0]   rdata_o,
  output logic [BW-1:0] base_hi_d_o,
  output logic          en_d_o,
  output logic          touch_o
);
  localparam logic [5:0]  BASE_DW = BASE_OFF[7:2];
  localparam logic [5:0]  EN_DW   = EN_OFF[7:2];
  localparam int unsigned EN_LANE = int'(EN_OFF[1:0]);

  logic [31:0] base_q, base_d;
  logic [7:0]  en_q, en_d;
  logic [3:0]  base_lane_wr;
  logic        en_wr;

  always_comb begin
    base_d = base_q;
    for (int i = 0; i < 4; i++) begin
      base_lane_wr[i] = lane_wr(we_i, waddr_i, BASE_DW, be_i[i]);
      if (base_lane_wr[i]) base_d[8*i +: 8] = wdata_i[8*i +: 8];
    end
    if (RO_BIT0) base_d[0] = 1'b1;
  end

  assign en_wr = lane_wr(we_i, waddr_i, EN_DW, be_i[EN_LANE]);
  assign en_d  = en_wr ? wdata_i[8*EN_LANE +: 8] : en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= BASE_INIT | {31'b0, RO_BIT0};
      en_q   <= EN_INIT;
    end else begin
      base_q <= base_d;
      en_q   <= en_d;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (raddr_i == BASE_DW) rdata_o = rdata_o | base_q;
    if (raddr_i == EN_DW)   rdata_o[8*EN_LANE +: 8] = rdata_o[8*EN_LANE +: 8] | en_q;
  end

  assign touch_o     = (|base_lane_wr) || en_wr;
  assign base_hi_d_o = base_d[IO_AW-1:ALIGN_W];
  assign en_d_o      = en_d[0];
endmodule

// File: rtl/io_win_state.sv
module io_win_state #(
  parameter int unsigned BW      = 10,
  parameter logic [BW-1:0] BASE_INIT = '0,
  parameter bit          EN_INIT = 1'b0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          touch_i,
  input  logic [BW-1:0] base_hi_d_i,
  input  logic          en_d_i,
  output logic [BW-1:0] base_hi_o,
  output logic          en_o
);
  // recompute only when a write touched this window's bytes
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_hi_o <= BASE_INIT;
      en_o      <= EN_INIT;
    end else if (touch_i) begin
      base_hi_o <= base_hi_d_i;
      en_o      <= en_d_i;
    end
  end
endmodule

// File: rtl/io_win_hit.sv
module io_win_hit
  import io_win_pkg::*;
#(
  parameter int unsigned IO_AW = 16,
  parameter int unsigned SIZE  = 64,
  localparam int unsigned BW = IO_AW - ALIGN_W
) (
  input  logic [IO_AW-1:0] io_addr_i,
  input  logic [BW-1:0]    base_hi_i,
  input  logic             en_i,
  output logic             hit_o,
  output logic [OFF_W-1:0] off_o
);
  localparam logic [OFF_W:0] SIZE_L = (OFF_W+1)'(SIZE);

  logic page_match, in_size;
  assign page_match = io_addr_i[IO_AW-1:ALIGN_W] == base_hi_i;
  assign in_size    = {1'b0, io_addr_i[ALIGN_W-1:0]} < SIZE_L;
  assign hit_o      = en_i && page_match && in_size;
  assign off_o      = io_addr_i[ALIGN_W-1:0];
endmodule

// File: rtl/io_win_decoder.sv
module io_win_decoder
  import io_win_pkg::*;
#(
  parameter int unsigned IO_AW        = 16,
  parameter logic [7:0]  PM_BASE_OFF  = 8'h40,
  parameter logic [7:0]  PM_EN_OFF    = 8'h80,
  parameter logic [7:0]  SMB_BASE_OFF = 8'h90,
  parameter logic [7:0]  SMB_EN_OFF   = 8'hD2,
  parameter int unsigned PM_SIZE      = 64,
  parameter int unsigned SMB_SIZE     = 16,
  parameter logic [15:0] SMB_BASE     = 16'h0B00
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [5:0]       cfg_waddr_i,
  input  logic [3:0]       cfg_be_i,
  input  logic [31:0]      cfg_wdata_i,
  input  logic [5:0]       cfg_raddr_i,
  output logic [31:0]      cfg_rdata_o,
  input  logic [IO_AW-1:0] io_addr_i,
  output logic             pm_hit_o,
  output logic [5:0]       pm_off_o,
  output logic             smb_hit_o,
  output logic [5:0]       smb_off_o
);
  localparam int unsigned BW = IO_AW - ALIGN_W;
  localparam logic [31:0] SMB_INIT = {16'h0, SMB_BASE | 16'h0001};

  logic [NUM_WIN-1:0][31:0]      rd;
  logic [NUM_WIN-1:0][BW-1:0]    win_base;
  logic [NUM_WIN-1:0][BW-1:0]    base_d;
  logic [NUM_WIN-1:0]            win_en, en_d, touch, hit;
  logic [NUM_WIN-1:0][OFF_W-1:0] off;

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
    localparam bit          IS_PM  = (g == WIN_PM);
    localparam logic [7:0]  B_OFF  = IS_PM ? PM_BASE_OFF : SMB_BASE_OFF;
    localparam logic [7:0]  E_OFF  = IS_PM ? PM_EN_OFF : SMB_EN_OFF;
    localparam logic [31:0] B_INIT = IS_PM ? 32'h0000_0001 : SMB_INIT;
    localparam logic [7:0]  E_INIT = IS_PM ? 8'h00 : 8'h09;
    localparam int unsigned SZ     = IS_PM ? PM_SIZE : SMB_SIZE;

    io_win_cfg #(
      .IO_AW(IO_AW), .BASE_OFF(B_OFF), .EN_OFF(E_OFF), .RO_BIT0(IS_PM),
      .BASE_INIT(B_INIT), .EN_INIT(E_INIT)
    ) u_cfg (
      .clk_i(clk_i), .rst_ni(rst_ni), .we_i(cfg_we_i), .waddr_i(cfg_waddr_i),
      .be_i(cfg_be_i), .wdata_i(cfg_wdata_i), .raddr_i(cfg_raddr_i),
      .rdata_o(rd[g]), .base_hi_d_o(base_d[g]), .en_d_o(en_d[g]), .touch_o(touch[g])
    );

    io_win_state #(
      .BW(BW), .BASE_INIT(B_INIT[IO_AW-1:ALIGN_W]), .EN_INIT(E_INIT[0])
    ) u_state (
      .clk_i(clk_i), .rst_ni(rst_ni), .touch_i(touch[g]), .base_hi_d_i(base_d[g]),
      .en_d_i(en_d[g]), .base_hi_o(win_base[g]), .en_o(win_en[g])
    );

    io_win_hit #(.IO_AW(IO_AW), .SIZE(SZ)) u_hit (
      .io_addr_i(io_addr_i), .base_hi_i(win_base[g]), .en_i(win_en[g]),
      .hit_o(hit[g]), .off_o(off[g])
    );
  end

  always_comb begin
    cfg_rdata_o = '0;
    for (int i = 0; i < NUM_WIN; i++) cfg_rdata_o = cfg_rdata_o | rd[i];
  end

  assign pm_hit_o  = hit[WIN_PM];
  assign pm_off_o  = off[WIN_PM];
  assign smb_hit_o = hit[WIN_SMB];
  assign smb_off_o = off[WIN_SMB];
endmodule

// File: rtl/io_win_decoder_chk.sv
module io_win_decoder_chk #(
  parameter int unsigned IO_AW       = 16,
  parameter logic [7:0]  PM_BASE_OFF = 8'h40,
  parameter int unsigned PM_SIZE     = 64,
  parameter int unsigned SMB_SIZE    = 16,
  localparam int unsigned BW = IO_AW - 6
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               cfg_we_i,
  input logic [5:0]         cfg_raddr_i,
  input logic [31:0]        cfg_rdata_o,
  input logic [IO_AW-1:0]   io_addr_i,
  input logic               pm_hit_o,
  input logic [5:0]         pm_off_o,
  input logic               smb_hit_o,
  input logic [5:0]         smb_off_o,
  input logic [1:0]         win_en,
  input logic [1:0][BW-1:0] win_base
);
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      AST_RST_PM_CLOSED: assert (!win_en[0] && !pm_hit_o); // R1
    end
  end

  AST_PM_BIT0_RO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_raddr_i == PM_BASE_OFF[7:2]) |-> cfg_rdata_o[0]); // R3

  AST_PM_HIT_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pm_hit_o |-> win_en[0]); // R4

  AST_SMB_HIT_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smb_hit_o |-> win_en[1]); // R5

  AST_PM_HIT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pm_hit_o |-> (io_addr_i[IO_AW-1:6] == win_base[0] && pm_off_o == io_addr_i[5:0]
                  && 7'(pm_off_o) < 7'(PM_SIZE))); // R7

  AST_SMB_HIT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smb_hit_o |-> (io_addr_i[IO_AW-1:6] == win_base[1] && smb_off_o == io_addr_i[5:0]
                   && 7'(smb_off_o) < 7'(SMB_SIZE))); // R7

  AST_WIN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_we_i |=> ($stable(win_en) && $stable(win_base))); // R10

  AST_HIT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_we_i |=> ($stable(io_addr_i) -> ($stable(pm_hit_o) && $stable(smb_hit_o)))); // R10
endmodule

bind io_win_decoder io_win_decoder_chk #(
  .IO_AW(IO_AW), .PM_BASE_OFF(PM_BASE_OFF), .PM_SIZE(PM_SIZE), .SMB_SIZE(SMB_SIZE)
) u_chk (.*);

// File: tb/sim_io_win_decoder.sv
module sim_io_win_decoder;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [5:0]  waddr = '0;
  logic [3:0]  be = '0;
  logic [31:0] wdata = '0;
  logic [5:0]  raddr = '0;
  logic [31:0] rdata;
  logic [15:0] io_addr = '0;
  logic        pm_hit, smb_hit;
  logic [5:0]  pm_off, smb_off;

  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  io_win_decoder u0 (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(we), .cfg_waddr_i(waddr), .cfg_be_i(be),
    .cfg_wdata_i(wdata), .cfg_raddr_i(raddr), .cfg_rdata_o(rdata), .io_addr_i(io_addr),
    .pm_hit_o(pm_hit), .pm_off_o(pm_off), .smb_hit_o(smb_hit), .smb_off_o(smb_off)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic cfg_wr(logic [5:0] a, logic [3:0] b, logic [31:0] d);
    @(negedge clk);
    we = 1'b1; waddr = a; be = b; wdata = d;
    @(negedge clk);
    we = 1'b0; be = '0;
  endtask

  task automatic rd_chk(string tag, logic [5:0] a, logic [31:0] exp);
    raddr = a;
    #1;
    chk(tag, rdata, exp);
  endtask

  task automatic probe(string tag, logic [15:0] a, logic ph, logic [5:0] po,
                       logic sh, logic [5:0] so);
    io_addr = a;
    #1;
    chk({tag, " pm_hit"}, 32'(pm_hit), 32'(ph));
    if (ph) chk({tag, " pm_off"}, 32'(pm_off), 32'(po));
    chk({tag, " smb_hit"}, 32'(smb_hit), 32'(sh));
    if (sh) chk({tag, " smb_off"}, 32'(smb_off), 32'(so));
  endtask

  task automatic t_reset();
    rd_chk("R1 pm base", 6'h10, 32'h0000_0001);
    rd_chk("R1 pm en", 6'h20, 32'h0);
    probe("R1 addr0", 16'h0000, 1'b0, 6'd0, 1'b0, 6'd0);
  endtask

  task automatic t_smb_init();
    rd_chk("R2 smb base", 6'h24, 32'h0000_0B01);
    rd_chk("R2 smb en", 6'h34, 32'h0009_0000);
    probe("R2 hit", 16'h0B05, 1'b0, 6'd0, 1'b1, 6'd5);
    probe("R7 smb end", 16'h0B10, 1'b0, 6'd0, 1'b0, 6'd0);
  endtask

  task automatic t_pm_program();
    cfg_wr(6'h10, 4'hF, 32'h0000_1234);
    rd_chk("R3 base ro bit", 6'h10, 32'h0000_1235);
    probe("R4 closed", 16'h1200, 1'b0, 6'd0, 1'b0, 6'd0);
    cfg_wr(6'h20, 4'h1, 32'h0000_0001);
    probe("R8 open now", 16'h1200, 1'b1, 6'd0, 1'b0, 6'd0);
    probe("R7 last", 16'h123F, 1'b1, 6'h3F, 1'b0, 6'd0);
    probe("R7 past end", 16'h1240, 1'b0, 6'd0, 1'b0, 6'd0);
    probe("R7 below", 16'h11FF, 1'b0, 6'd0, 1'b0, 6'd0);
  endtask

  task automatic t_lanes();
    cfg_wr(6'h10, 4'b0010, 32'h0000_5600);
    rd_chk("R6 lane1", 6'h10, 32'h0000_5635);
    probe("R6 moved", 16'h5610, 1'b1, 6'h10, 1'b0, 6'd0);
    probe("R6 old", 16'h1210, 1'b0, 6'd0, 1'b0, 6'd0);
    cfg_wr(6'h10, 4'b0100, 32'h00FF_0000);
    rd_chk("R6 lane2", 6'h10, 32'h00FF_5635);
    probe("R6 lane2 base", 16'h5610, 1'b1, 6'h10, 1'b0, 6'd0);
  endtask

  task automatic t_ro_bit();
    cfg_wr(6'h10, 4'b0001, 32'h0000_0000);
    rd_chk("R3 bit0 stays", 6'h10, 32'h00FF_5601);
  endtask

  task automatic t_unrelated();
    cfg_wr(6'h11, 4'hF, 32'hFFFF_FFFF);
    cfg_wr(6'h20, 4'b1110, 32'hFFFF_FF00);
    cfg_wr(6'h34, 4'b1011, 32'hFFFF_FFFF);
    rd_chk("R9 unowned", 6'h11, 32'h0);
    rd_chk("R9 pm en", 6'h20, 32'h0000_0001);
    rd_chk("R9 smb en", 6'h34, 32'h0009_0000);
    probe("R9 pm still", 16'h5610, 1'b1, 6'h10, 1'b0, 6'd0);
    probe("R9 smb still", 16'h0B02, 1'b0, 6'd0, 1'b1, 6'd2);
  endtask

  task automatic t_smb_prog();
    cfg_wr(6'h24, 4'b0011, 32'h0000_2040);
    rd_chk("R5 smb base", 6'h24, 32'h0000_2040);
    probe("R5 smb hit", 16'h2043, 1'b0, 6'd0, 1'b1, 6'd3);
    probe("R5 smb old", 16'h0B02, 1'b0, 6'd0, 1'b0, 6'd0);
    cfg_wr(6'h34, 4'b0100, 32'h0000_0000);
    rd_chk("R5 smb en rd", 6'h34, 32'h0);
    probe("R5 smb closed", 16'h2043, 1'b0, 6'd0, 1'b0, 6'd0);
  endtask

  task automatic t_pm_disable();
    cfg_wr(6'h20, 4'b0001, 32'h0000_00FE);
    rd_chk("R4 en byte", 6'h20, 32'h0000_00FE);
    probe("R4 closed", 16'h5610, 1'b0, 6'd0, 1'b0, 6'd0);
    repeat (3) @(negedge clk);
    probe("R10 hold", 16'h5610, 1'b0, 6'd0, 1'b0, 6'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_smb_init();
    t_pm_program();
    t_lanes();
    t_ro_bit();
    t_unrelated();
    t_smb_prog();
    t_pm_disable();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule